// File: doc/BRIEF.md
# Serial-Port Conversion Sequencer for a Four-Input Bipolar SAR Converter

This block is the digital core of a 16-bit successive-approximation converter with four analog inputs and a synchronous serial port. All of its logic runs on the serial clock (`sclk`) and the active-low chip select (`cs_n`). While the port is selected, the block watches the serial input for a start bit. It then collects the control byte that follows, sets the input multiplexer, and acquires the input. Once the byte is complete it holds the sample, signals a one-clock busy slot, and performs sixteen bit decisions against a comparator. Each decided bit is shifted out on a falling clock edge.

The analog side is modelled at the ports. `dac_code` is the two's-complement trial value that the capacitor array would present. `cmp_in` is the comparator answer, high when the held input is at or above that trial value. The multiplexer selection appears as a positive and a negative input index, where index 4 means the common input. A power status flag and a clock-mode flag carry the decoded power field out of the block.

Controller states: `S_HUNT` (waiting for a start bit), `S_CTRL` (receiving the seven bits after the start bit), `S_SLOT` (busy slot, MSB decision pending) and `S_CONV` (remaining decisions). Transitions: `S_HUNT` to `S_CTRL` when DIN is high on a rising edge; `S_CTRL` to `S_SLOT` on the edge that captures the last control bit; `S_SLOT` to `S_CONV` after one clock; `S_CONV` to `S_HUNT` on the edge that decides the LSB. Chip select high forces `S_HUNT` from any state.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is low and the block is hunting, a low DIN on a rising `sclk` edge is ignored. The first rising edge that samples DIN high is the start bit. The next seven rising edges capture, in order: channel bits C2, C1, C0, one spare bit that is ignored, the mode bit M (1 = single-ended, 0 = differential), then the power bits P1 and P0.
- R2: The channel index is {C1, C2}, so codes C2C1C0 = 001, 101, 010 and 110 select inputs 0, 1, 2 and 3. `mux_pos` takes this index on the edge that captures C0. On the edge that captures M, `mux_neg` becomes 4 (the common input) if M = 1, or the index XOR 1 if M = 0. After reset, `mux_pos` = 0 and `mux_neg` = 4.
- R3: `acquire` goes high after the edge that captures C0 and stays high for exactly four clocks. It is low again after the edge that captures P0, at which point the sample is held.
- R4: `busy` goes high on the falling edge that follows the P0 edge and stays high for exactly one clock period.
- R5: The comparator is sampled on the 16 rising edges that follow the P0 edge. The first trial code is 0. The result is the two's-complement code of the largest trial value not above the input, so for inputs from -32768 to 32767 the result equals the input (0x7FFF, 0x8000 and 0xFFFF included).
- R6: DOUT presents the result MSB first, one bit per falling edge. Bit 15 appears on the falling edge where `busy` falls. After bit 0, DOUT is 0 on every falling edge until the next result begins.
- R7: While `cs_n` is high, `busy_oe` and `dout_oe` are low. After `cs_n` falls, `busy` reads 0 and `dout` reads 0.
- R8: DIN is ignored during the busy slot and the 16 decision edges. A start bit is accepted on the rising edge right after the LSB decision, so conversions can follow each other every 24 clocks.
- R9: `powered` is low only while hunting, and only when the last completed control byte had P1P0 = 00. It is high in every other case. After reset, P1P0 = 00.
- R10: `int_clk_sel` is updated on each P0 edge. It takes the value "the previous completed control byte had P1P0 = 10", so a clock-mode change takes effect one conversion late. It is 0 after reset.
- R11: Chip select rising in the middle of a frame discards the partial control byte. The block then hunts for a new start bit, and the multiplexer and power settings are left unchanged if the edges that load them were not reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; rising edges sample DIN and the comparator, falling edges drive outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high aborts and tri-states the outputs |
| din | input | 1 | Serial control input |
| cmp_in | input | 1 | Comparator: 1 when the held input is at or above `dac_code` |
| dac_code | output | RES_BITS | Two's-complement trial value for the capacitor array |
| acquire | output | 1 | Input sampling window |
| mux_pos | output | 3 | Positive multiplexer input index (0..3) |
| mux_neg | output | 3 | Negative multiplexer input index (0..3, 4 = common) |
| powered | output | 1 | Analog section powered |
| int_clk_sel | output | 1 | Internal conversion clock mode in effect |
| busy | output | 1 | Busy slot flag |
| busy_oe | output | 1 | Output enable for `busy` |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
A wrong bit counter or state shifts the busy pulse off the cycle that is exactly nine rising edges after the start bit. The scoreboard catches this on the first conversion. A leftover control bit after an abort shows up the same way, on the frame that follows. A fault in the trial-bit update or the sign handling corrupts the 16-bit word read from DOUT within one conversion, and the boundary codes 0x7FFF, 0x8000 and 0xFFFF expose errors in the sign bit. A fault in decoding the multiplexer or power fields is visible on `mux_pos`, `mux_neg`, `powered` or `int_clk_sel` within one to seven clocks after the edge that captures the field.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_CTRL = 2'd1,
        S_SLOT = 2'd2,
        S_CONV = 2'd3
    } seq_state_t;

    localparam int MUX_W = 3;
    localparam logic [MUX_W-1:0] MUX_COM = 3'd4;

    // bit counter values while receiving the seven bits after the start bit
    localparam int CCNT_W = 3;
    localparam logic [CCNT_W-1:0] CC_CHAN = 3'd2;  // edge capturing C0
    localparam logic [CCNT_W-1:0] CC_ACQ  = 3'd3;  // first count with acquire high
    localparam logic [CCNT_W-1:0] CC_MODE = 3'd4;  // edge capturing M
    localparam logic [CCNT_W-1:0] CC_LAST = 3'd6;  // edge capturing P0

    localparam logic [1:0] PD_SLEEP  = 2'b00;
    localparam logic [1:0] PD_INTCLK = 2'b10;

    function automatic logic [MUX_W-1:0] chan_index(input logic c2, input logic c1);
        return {1'b0, c1, c2};
    endfunction

    function automatic logic [MUX_W-1:0] neg_index(input logic [MUX_W-1:0] idx, input logic single);
        return single ? MUX_COM : (idx ^ 3'd1);
    endfunction

endpackage

// File: rtl/sar_mux_sel.sv
module sar_mux_sel
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos_load,
    input  logic             neg_load,
    input  logic             c2,
    input  logic             c1,
    input  logic             single,
    output logic [MUX_W-1:0] mux_pos,
    output logic [MUX_W-1:0] mux_neg
);

    logic [MUX_W-1:0] pos_q;
    logic [MUX_W-1:0] neg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            neg_q <= MUX_COM;
        end else begin
            if (pos_load) pos_q <= chan_index(c2, c1);
            if (neg_load) neg_q <= neg_index(pos_q, single);
        end
    end

    assign mux_pos = pos_q;
    assign mux_neg = neg_q;

    // R2: single-ended mode references the common input
    assert_com_on_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_load && single) |=> (mux_neg == MUX_COM));

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load,
    input  logic         step,
    input  logic         cmp,
    output logic [N-1:0] trial,
    output logic         dec_bit,
    output logic         dec_vld
);

    localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

    // acc_q is kept in offset binary; the sign flip happens at the output
    logic [N-1:0] acc_q;
    logic [N-1:0] mask_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            acc_q   <= '0;
            mask_q  <= '0;
            dec_bit <= 1'b0;
            dec_vld <= 1'b0;
        end else begin
            dec_vld <= step;
            if (load) begin
                acc_q  <= TOP;
                mask_q <= TOP;
            end else if (step) begin
                acc_q   <= (cmp ? acc_q : (acc_q & ~mask_q)) | (mask_q >> 1);
                mask_q  <= mask_q >> 1;
                dec_bit <= cmp ^ mask_q[N-1];
            end
        end
    end

    assign trial = acc_q ^ TOP;

    // R5: the first trial after a load is signed zero
    assert_first_trial_zero_R5: assert property (@(posedge clk) disable iff (!clr_n)
        load |=> (trial == '0));

    // R5: at most one trial bit is pending
    assert_mask_onehot_R5: assert property (@(posedge clk) disable iff (!clr_n)
        step |-> $onehot0(mask_q));

endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage (
    input  logic clk,
    input  logic clr_n,
    input  logic cs_n,
    input  logic slot,
    input  logic dec_vld,
    input  logic dec_bit,
    output logic busy,
    output logic busy_oe,
    output logic dout,
    output logic dout_oe
);

    logic busy_q;
    logic dout_q;

    always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n) begin
            busy_q <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            busy_q <= slot;
            dout_q <= dec_vld & dec_bit;
        end
    end

    assign busy    = busy_q;
    assign dout    = dout_q;
    assign busy_oe = ~cs_n;
    assign dout_oe = ~cs_n;

    // R4: the busy flag never lasts two falling edges
    assert_busy_one_clk_R4: assert property (@(negedge clk) disable iff (!clr_n)
        busy_q |=> !busy_q);

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                din,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic                acquire,
    output logic [MUX_W-1:0]    mux_pos,
    output logic [MUX_W-1:0]    mux_neg,
    output logic                powered,
    output logic                int_clk_sel,
    output logic                busy,
    output logic                busy_oe,
    output logic                dout,
    output logic                dout_oe
);

    localparam int BCNT_W = $clog2(RES_BITS);
    localparam logic [BCNT_W-1:0] BC_LAST = BCNT_W'(RES_BITS - 1);

    logic              clr_n;
    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [CCNT_W-1:0] ccnt_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [1:0]        tail_q;
    logic [1:0]        pd_cfg_q;
    logic              int_clk_q;

    logic pos_load;
    logic neg_load;
    logic cfg_load;
    logic sar_step;
    logic slot_flag;
    logic dec_bit;
    logic dec_vld;

    assign clr_n = rst_n & ~cs_n;

    // state register
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT: if (din) state_d = S_CTRL;
            S_CTRL: if (ccnt_q == CC_LAST) state_d = S_SLOT;
            S_SLOT: state_d = S_CONV;
            S_CONV: if (bcnt_q == BC_LAST) state_d = S_HUNT;
            default: state_d = S_HUNT;
        endcase
    end

    // decoded outputs and strobes
    always_comb begin
        acquire   = (state_q == S_CTRL) && (ccnt_q >= CC_ACQ);
        pos_load  = (state_q == S_CTRL) && (ccnt_q == CC_CHAN);
        neg_load  = (state_q == S_CTRL) && (ccnt_q == CC_MODE);
        cfg_load  = (state_q == S_CTRL) && (ccnt_q == CC_LAST);
        sar_step  = (state_q == S_SLOT) || (state_q == S_CONV);
        slot_flag = (state_q == S_SLOT);
        powered   = !((state_q == S_HUNT) && (pd_cfg_q == PD_SLEEP));
    end

    // frame counters and control byte tail
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) begin
            ccnt_q <= '0;
            bcnt_q <= '0;
            tail_q <= '0;
        end else begin
            unique case (state_q)
                S_HUNT: begin
                    ccnt_q <= '0;
                    tail_q <= '0;
                end
                S_CTRL: begin
                    ccnt_q <= ccnt_q + CCNT_W'(1);
                    tail_q <= {tail_q[0], din};
                end
                S_SLOT: bcnt_q <= BCNT_W'(1);
                S_CONV: bcnt_q <= bcnt_q + BCNT_W'(1);
                default: ccnt_q <= '0;
            endcase
        end
    end

    // power and clock-mode settings survive chip select
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            pd_cfg_q  <= PD_SLEEP;
            int_clk_q <= 1'b0;
        end else if (cfg_load) begin
            pd_cfg_q  <= {tail_q[0], din};
            int_clk_q <= (pd_cfg_q == PD_INTCLK);
        end
    end

    assign int_clk_sel = int_clk_q;

    sar_mux_sel u_mux (
        .clk      (sclk),
        .rst_n    (rst_n),
        .pos_load (pos_load),
        .neg_load (neg_load),
        .c2       (tail_q[1]),
        .c1       (tail_q[0]),
        .single   (din),
        .mux_pos  (mux_pos),
        .mux_neg  (mux_neg)
    );

    sar_approx #(.N(RES_BITS)) u_sar (
        .clk     (sclk),
        .clr_n   (clr_n),
        .load    (cfg_load),
        .step    (sar_step),
        .cmp     (cmp_in),
        .trial   (dac_code),
        .dec_bit (dec_bit),
        .dec_vld (dec_vld)
    );

    sar_out_stage u_out (
        .clk     (sclk),
        .clr_n   (clr_n),
        .cs_n    (cs_n),
        .slot    (slot_flag),
        .dec_vld (dec_vld),
        .dec_bit (dec_bit),
        .busy    (busy),
        .busy_oe (busy_oe),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    // R1: a low DIN while hunting leaves the block hunting
    assert_hunt_ignores_low_R1: assert property (@(posedge sclk) disable iff (!clr_n)
        (state_q == S_HUNT && !din) |=> (state_q == S_HUNT));

    // R3: the acquire window is four clocks long when it closes
    assert_acq_window_R3: assert property (@(posedge sclk) disable iff (!clr_n)
        $fell(acquire) |-> $past(acquire, 4));

    // R8: hunting resumes right after the last decision
    assert_conv_ends_R8: assert property (@(posedge sclk) disable iff (!clr_n)
        (state_q == S_CONV && bcnt_q == BC_LAST) |=> (state_q == S_HUNT));

endmodule

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb;

    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;
    logic signed [N-1:0] vin = '0;
    logic cmp;

    logic [N-1:0] dac_code;
    logic acquire, powered, int_clk_sel, busy, busy_oe, dout, dout_oe;
    logic [2:0] mux_pos, mux_neg;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [1:0] pd_hist = 2'b00;
    logic [2:0] last_pos = 3'd0;

    logic [N-1:0] exp_code[$];
    int           exp_cyc[$];

    assign cmp = ($signed(dac_code) <= vin);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sar_serial_seq #(.RES_BITS(N)) u_dut (
        .sclk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .cmp_in(cmp),
        .dac_code(dac_code), .acquire(acquire), .mux_pos(mux_pos), .mux_neg(mux_neg),
        .powered(powered), .int_clk_sel(int_clk_sel), .busy(busy), .busy_oe(busy_oe),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            din = 1'b0;
        end
    endtask

    // driver: one full 24-clock frame, expected result pushed to the scoreboard
    task automatic conv(input logic [2:0] chan, input bit single, input logic [1:0] pd,
                        input logic signed [N-1:0] v, input bit junk);
        logic [6:0] bits;
        logic [2:0] idx;
        logic [2:0] neg;
        idx  = {1'b0, chan[1], chan[2]};
        neg  = single ? 3'd4 : (idx ^ 3'd1);
        bits = {chan, 1'b0, single, pd};
        @(negedge clk);
        vin = v;
        din = 1'b1;
        exp_code.push_back(v);
        exp_cyc.push_back(cyc + 9);
        @(posedge clk) #3;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            din = bits[6-i];
            @(posedge clk) #3;
            if (i == 1) chk(acquire == 1'b0, "R3", "acquire before C0", acquire, 0);
            if (i == 2) begin
                chk(acquire == 1'b1, "R3", "acquire after C0", acquire, 1);
                chk(mux_pos == idx, "R2", "mux_pos", mux_pos, idx);
                last_pos = idx;
            end
            if (i == 4) chk(mux_neg == neg, "R2", "mux_neg", mux_neg, neg);
            if (i == 6) begin
                chk(acquire == 1'b0, "R3", "acquire after P0", acquire, 0);
                chk(int_clk_sel == (pd_hist == 2'b10), "R10", "int_clk_sel",
                    int_clk_sel, (pd_hist == 2'b10));
                chk(powered == 1'b1, "R9", "powered during conversion", powered, 1);
            end
        end
        pd_hist = pd;
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            din = (j < 15) ? junk : 1'b0;   // R8: DIN high here must be ignored
            @(posedge clk) #3;
        end
        chk(powered == (pd != 2'b00), "R9", "powered while hunting", powered, (pd != 2'b00));
    endtask

    // monitor: pops expected results as busy pulses appear
    initial begin
        forever begin
            @(posedge clk) #3;
            if (!cs_n && busy_oe && busy) begin
                logic [N-1:0] got;
                logic [N-1:0] want;
                int           wcyc;
                if (exp_code.size() == 0) begin
                    chk(1'b0, "R4", "unexpected busy", cyc, 0);
                end else begin
                    want = exp_code.pop_front();
                    wcyc = exp_cyc.pop_front();
                    chk(cyc == wcyc, "R4", "busy cycle (R1 framing)", cyc, wcyc);
                    @(posedge clk) #3;
                    chk(busy == 1'b0, "R4", "busy one clock", busy, 0);
                    got = '0;
                    got[N-1] = dout;
                    for (int b = 1; b < N; b++) begin
                        @(posedge clk) #3;
                        got[N-1-b] = dout;
                    end
                    chk(got == want, "R5", "result word on DOUT (R6 order)", got, want);
                    @(posedge clk) #3;
                    if (!cs_n) chk(dout == 1'b0, "R6", "zero fill after LSB", dout, 0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk) #3;
        chk(busy_oe == 1'b0, "R7", "busy_oe with cs high", busy_oe, 0);
        chk(dout_oe == 1'b0, "R7", "dout_oe with cs high", dout_oe, 0);
        chk(powered == 1'b0, "R9", "powered after reset", powered, 0);
        chk(int_clk_sel == 1'b0, "R10", "int_clk_sel after reset", int_clk_sel, 0);
        chk(mux_neg == 3'd4, "R2", "mux_neg after reset", mux_neg, 4);

        @(negedge clk) #1 cs_n = 1'b0;
        @(posedge clk) #3;
        chk(busy_oe && !busy, "R7", "busy low after cs falls", busy, 0);
        chk(dout_oe && !dout, "R7", "dout low after cs falls", dout, 0);

        idle(3);                                   // R1: leading zeros are hunted through
        conv(3'b001, 1'b1, 2'b11, 16'sh1234, 1'b0);
        conv(3'b101, 1'b0, 2'b10, 16'sh7FFF, 1'b0); // R8: back to back
        conv(3'b010, 1'b1, 2'b11, -16'sd32768, 1'b1);
        conv(3'b110, 1'b0, 2'b00, -16'sd1, 1'b1);
        idle(2);
        chk(powered == 1'b0, "R9", "sleep between conversions", powered, 0);
        conv(3'b011, 1'b0, 2'b01, 16'sh0000, 1'b0);
        conv(3'b111, 1'b1, 2'b11, -16'sd12345, 1'b0);
        idle(4);

        // R11: abort after the start bit and C2
        @(negedge clk) din = 1'b1;
        @(negedge clk) din = 1'b1;
        @(negedge clk) din = 1'b0;
        #1 cs_n = 1'b1;
        @(posedge clk) #3;
        chk(!busy_oe && !dout_oe, "R7", "outputs disabled on abort", busy_oe, 0);
        chk(mux_pos == last_pos, "R11", "mux kept after abort", mux_pos, last_pos);
        idle(2);
        @(negedge clk) #1 cs_n = 1'b0;
        @(posedge clk) #3;
        chk(busy_oe && !busy, "R11", "busy low after reselect", busy, 0);
        conv(3'b100, 1'b1, 2'b11, 16'sh5A5A, 1'b0);
        conv(3'b001, 1'b0, 2'b11, 16'sh0001, 1'b1);
        idle(30);
        chk(exp_code.size() == 0, "R5", "all results delivered", exp_code.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule